// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the active-low processor reset for a board-level controller. It pulls reset low for four reasons: the supply is reported as not good, the supply has just come good (or the block itself has just left its own reset), the user presses a pushbutton wired onto the reset line, or software fails to service a watchdog in time. All timing is counted in ticks of an external one-millisecond strobe, so the block runs from any system clock.

The pushbutton level arrives already synchronized; it goes low while the button is held. A press is only acted on while no reset pulse is being produced. After the first fixed pulse, a button that is still held makes the block let go of the line and wait for release. Release then triggers a second fixed pulse. The watchdog is serviced by high-to-low transitions on an asynchronous active-low strobe. Its timeout comes from a two-bit period field that software writes through a simple write-enable port.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_good` is low, `rst_out_n` is low; a drop of `pwr_good` pulls `rst_out_n` low one clock later from any state.
- R2: After `rst_n` is released, or after `pwr_good` returns high, `rst_out_n` stays low for exactly PULSE_MS ticks of `ms_tick` and then goes high.
- R3: While no reset pulse is running, a high-to-low change of `pb_level` starts a reset pulse of PULSE_MS ticks.
- R4: A press that begins while a reset pulse is running is ignored, even if the button is still held when the pulse ends.
- R5: If `pb_level` is still low when a pushbutton pulse ends, `rst_out_n` goes high and the block waits; a later low-to-high change of `pb_level` starts a second pulse of PULSE_MS ticks. If the button is already released, normal operation resumes.
- R6: Period code in `cfg_period`: 2'b00 disables the watchdog, 2'b01 gives WD_BASE_MS ticks, 2'b10 gives 2*WD_BASE_MS and 2'b11 gives 4*WD_BASE_MS. The watchdog counts ticks only while reset is inactive. On expiry it starts a reset pulse of PULSE_MS ticks.
- R7: After `rst_n`, the period code is 2'b11.
- R8: `wd_strobe_n` passes through a two-flop synchronizer. Each high-to-low change restarts the watchdog count, and the count is held at zero while reset is asserted.
- R9: Any write of the period field (`cfg_we` high) restarts the watchdog count.
- R10: Causes are prioritized as supply fault, then pushbutton, then watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pwr_good | input | 1 | Supply in tolerance, synchronous |
| pb_level | input | 1 | Synchronized reset-line level, low while pressed |
| wd_strobe_n | input | 1 | Asynchronous active-low watchdog service strobe |
| cfg_we | input | 1 | Write strobe for the period field |
| cfg_period | input | 2 | Period code written when `cfg_we` is high |
| rst_out_n | output | 1 | Active-low reset to the processor |

## Verification
A wrong pulse counter shows up as a reset pulse that is one or more ticks too long or too short, and it is visible on `rst_out_n` at the edge where the pulse should end. A corrupted watchdog count or period code moves the expiry edge, or makes it vanish. A stale strobe synchronizer shifts every restart by whole cycles, so a tightly timed service either lets the timer expire or keeps it alive. These faults appear within one watchdog period. A wrong sequencer state, for example a missed wait-for-release, changes the number of low pulses per press. The bench compares `rst_out_n` against a cycle-accurate reference on every clock, so any of these faults fails at the first cycle where the output differs.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    ST_PDOWN = 2'd0,
    ST_HOLD  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } rsv_state_e;

  localparam logic [1:0] WD_OFF = 2'b00;
  localparam logic [1:0] WD_X1  = 2'b01;
  localparam logic [1:0] WD_X2  = 2'b10;
  localparam logic [1:0] WD_X4  = 2'b11;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{1'b1}};
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog
  import rsv_pkg::*;
#(
  parameter int WD_BASE_MS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       kick,
  input  logic       cfg_we,
  input  logic [1:0] cfg_period,
  output logic       expire
);
  localparam int CW = $clog2(4 * WD_BASE_MS + 1);
  localparam logic [CW-1:0] LIM1 = CW'(WD_BASE_MS);
  localparam logic [CW-1:0] LIM2 = CW'(2 * WD_BASE_MS);
  localparam logic [CW-1:0] LIM4 = CW'(4 * WD_BASE_MS);

  logic [1:0]    period_q, period_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;
  logic          restart;

  always_comb begin
    case (period_q)
      WD_X1:   limit = LIM1;
      WD_X2:   limit = LIM2;
      WD_X4:   limit = LIM4;
      default: limit = LIM4;
    endcase
    restart  = ~run | kick | cfg_we | (period_q == WD_OFF);
    expire   = ~restart & tick & (cnt_q == limit - CW'(1));
    period_d = cfg_we ? cfg_period : period_q;
    if (restart || expire) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= WD_X4;
      cnt_q    <= '0;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
    end
  end

  // R8
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R6
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LIM4);
endmodule

// File: rtl/rsv_seq.sv
module rsv_seq
  import rsv_pkg::*;
#(
  parameter int PULSE_MS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pwr_good,
  input  logic       pb_level,
  input  logic       wd_expire,
  output rsv_state_e state,
  output logic       rst_out_n
);
  localparam int HW = (PULSE_MS > 1) ? $clog2(PULSE_MS) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(PULSE_MS - 1);

  rsv_state_e    state_q, state_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          pbflag_q, pbflag_d;
  logic          pbprev_q;
  logic          pb_fall, pb_rise, hold_end;

  always_comb begin
    pb_fall  = pbprev_q & ~pb_level;
    pb_rise  = ~pbprev_q & pb_level;
    hold_end = tick & (hold_q == HOLD_LAST);
    state_d  = state_q;
    hold_d   = hold_q;
    pbflag_d = pbflag_q;
    if (!pwr_good) begin
      state_d  = ST_PDOWN;
      hold_d   = '0;
      pbflag_d = 1'b0;
    end else begin
      case (state_q)
        ST_PDOWN: begin
          state_d = ST_HOLD;
          hold_d  = '0;
        end
        ST_HOLD: begin
          if (hold_end) begin
            hold_d   = '0;
            pbflag_d = 1'b0;
            state_d  = (pbflag_q && !pb_level) ? ST_WAIT : ST_RUN;
          end else if (tick) begin
            hold_d = hold_q + HW'(1);
          end
        end
        ST_WAIT: begin
          if (pb_rise) begin
            state_d = ST_HOLD;
            hold_d  = '0;
          end
        end
        default: begin
          if (pb_fall) begin
            state_d  = ST_HOLD;
            hold_d   = '0;
            pbflag_d = 1'b1;
          end else if (wd_expire) begin
            state_d = ST_HOLD;
            hold_d  = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HOLD;
      hold_q   <= '0;
      pbflag_q <= 1'b0;
      pbprev_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      hold_q   <= hold_d;
      pbflag_q <= pbflag_d;
      pbprev_q <= pb_level;
    end
  end

  assign state     = state_q;
  assign rst_out_n = (state_q == ST_RUN) || (state_q == ST_WAIT);

  // R1
  pwr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !rst_out_n);

  // R3
  hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HOLD_LAST);

  // R2
  rise_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(pwr_good));

  // R5
  wait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) && pwr_good && !pb_level |=> rst_out_n);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int PULSE_MS   = 250,
  parameter int WD_BASE_MS = 250,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       pwr_good,
  input  logic       pb_level,
  input  logic       wd_strobe_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_period,
  output logic       rst_out_n
);
  rsv_state_e state;
  logic       kick;
  logic       wd_expire;
  logic       run;

  assign run = (state == ST_RUN);

  rsv_sync #(.STAGES(SYNC_DEPTH)) u_strobe_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wd_strobe_n),
    .fall  (kick)
  );

  rsv_watchdog #(.WD_BASE_MS(WD_BASE_MS)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (ms_tick),
    .run        (run),
    .kick       (kick),
    .cfg_we     (cfg_we),
    .cfg_period (cfg_period),
    .expire     (wd_expire)
  );

  rsv_seq #(.PULSE_MS(PULSE_MS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (ms_tick),
    .pwr_good  (pwr_good),
    .pb_level  (pb_level),
    .wd_expire (wd_expire),
    .state     (state),
    .rst_out_n (rst_out_n)
  );

  // R10
  expire_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |-> rst_out_n);
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int PULSE = 250;
  localparam int BASE  = 250;
  localparam int M_PDOWN = 0, M_HOLD = 1, M_WAIT = 2, M_RUN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b1;
  logic pwr_good = 1'b1;
  logic pb_level = 1'b1;
  logic wd_strobe_n = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_period = 2'b00;
  logic rst_out_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  rst_supervisor u_rst_supervisor (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_good(pwr_good),
    .pb_level(pb_level), .wd_strobe_n(wd_strobe_n), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .rst_out_n(rst_out_n)
  );

  function automatic int wd_ticks(input logic [1:0] code);
    case (code)
      2'b01:   return BASE;
      2'b10:   return 2 * BASE;
      2'b11:   return 4 * BASE;
      default: return 0;
    endcase
  endfunction

  // reference model of the requirements, cycle accurate
  int m_st, m_h, m_w;
  bit m_pbf, m_pbp, s1, s2, sp;
  logic [1:0] m_per;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_HOLD; m_h = 0; m_w = 0; m_pbf = 0; m_pbp = 1;
      m_per = 2'b11; s1 = 1; s2 = 1; sp = 1;
    end else begin : model
      bit kick, restart, expire;
      int nst, nh, nw;
      bit npbf;
      kick    = sp && !s2;
      restart = (m_st != M_RUN) || kick || cfg_we || (m_per == 2'b00);
      expire  = !restart && ms_tick && (m_w == wd_ticks(m_per) - 1);
      nw = (restart || expire) ? 0 : (ms_tick ? m_w + 1 : m_w);
      nst = m_st; nh = m_h; npbf = m_pbf;
      if (!pwr_good) begin
        nst = M_PDOWN; nh = 0; npbf = 0;
      end else if (m_st == M_PDOWN) begin
        nst = M_HOLD; nh = 0;
      end else if (m_st == M_HOLD) begin
        if (ms_tick && m_h == PULSE - 1) begin
          nh = 0; npbf = 0;
          nst = (m_pbf && !pb_level) ? M_WAIT : M_RUN;
        end else if (ms_tick) nh = m_h + 1;
      end else if (m_st == M_WAIT) begin
        if (!m_pbp && pb_level) begin nst = M_HOLD; nh = 0; end
      end else begin
        if (m_pbp && !pb_level) begin nst = M_HOLD; nh = 0; npbf = 1; end
        else if (expire) begin nst = M_HOLD; nh = 0; end
      end
      if (cfg_we) m_per = cfg_period;
      m_st = nst; m_h = nh; m_w = nw; m_pbf = npbf; m_pbp = pb_level;
      sp = s2; s2 = s1; s1 = wd_strobe_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin : cmp
      int exp_out;
      exp_out = (m_st == M_RUN || m_st == M_WAIT) ? 1 : 0;
      check(rst_out_n == exp_out[0], cur_req, int'(rst_out_n), exp_out);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick_strobe();
    wd_strobe_n = 1'b0; wait_cyc(3); wd_strobe_n = 1'b1; wait_cyc(1);
  endtask

  task automatic write_period(input logic [1:0] code);
    cfg_period = code; cfg_we = 1'b1; wait_cyc(1); cfg_we = 1'b0;
  endtask

  initial begin
    int lows;
    wait_cyc(3);
    check(rst_out_n == 1'b0, "R2 reset state", int'(rst_out_n), 0);
    rst_n = 1'b1;
    cur_req = "R2";
    wait_cyc(PULSE + 5);
    check(rst_out_n == 1'b1, "R2 power-up hold ends", int'(rst_out_n), 1);

    // R7 default period 4*BASE expires with no service
    cur_req = "R7";
    lows = 0;
    for (int i = 0; i < 4 * BASE + 10; i++) begin
      wait_cyc(1);
      if (!rst_out_n) lows++;
    end
    check(lows > 0, "R7 default period expiry", lows, 1);
    wait_cyc(PULSE + 5);

    // R8 periodic service keeps reset off
    cur_req = "R8";
    lows = 0;
    for (int i = 0; i < 12; i++) begin
      wait_cyc(300);
      if (!rst_out_n) lows++;
      kick_strobe();
    end
    check(lows == 0, "R8 serviced watchdog", lows, 0);

    // R6 / R9 each period code, service by write
    cur_req = "R9";
    write_period(2'b01);
    wait_cyc(200);
    write_period(2'b01);
    wait_cyc(200);
    check(rst_out_n == 1'b1, "R9 write restarts count", int'(rst_out_n), 1);
    cur_req = "R6";
    wait_cyc(PULSE + 100);
    write_period(2'b10);
    wait_cyc(2 * BASE + PULSE + 10);
    write_period(2'b00);
    lows = 0;
    for (int i = 0; i < 5000; i++) begin
      wait_cyc(1);
      if (!rst_out_n) lows++;
    end
    check(lows == 0, "R6 code 00 disables", lows, 0);

    // R3 short press
    cur_req = "R3";
    pb_level = 1'b0; wait_cyc(10); pb_level = 1'b1;
    wait_cyc(5);
    check(rst_out_n == 1'b0, "R3 press starts pulse", int'(rst_out_n), 0);
    wait_cyc(PULSE + 5);
    check(rst_out_n == 1'b1, "R3 pulse ends", int'(rst_out_n), 1);

    // R5 long press: wait for release, then second pulse
    cur_req = "R5";
    pb_level = 1'b0;
    wait_cyc(PULSE + 50);
    check(rst_out_n == 1'b1, "R5 released while held", int'(rst_out_n), 1);
    wait_cyc(100);
    pb_level = 1'b1;
    wait_cyc(5);
    check(rst_out_n == 1'b0, "R5 second pulse on release", int'(rst_out_n), 0);
    wait_cyc(PULSE + 5);

    // R4 press during a running pulse is ignored
    cur_req = "R4";
    pwr_good = 1'b0; wait_cyc(20);
    cur_req = "R1";
    check(rst_out_n == 1'b0, "R1 supply fault holds reset", int'(rst_out_n), 0);
    pwr_good = 1'b1;
    cur_req = "R4";
    wait_cyc(20);
    pb_level = 1'b0;
    wait_cyc(PULSE + 20);
    check(rst_out_n == 1'b1, "R4 press inside pulse ignored", int'(rst_out_n), 1);
    pb_level = 1'b1;
    wait_cyc(20);
    check(rst_out_n == 1'b1, "R4 release not acted on", int'(rst_out_n), 1);

    // R10 supply fault wins over a pending press and over wait state
    cur_req = "R10";
    pb_level = 1'b0;
    wait_cyc(PULSE + 30);
    pwr_good = 1'b0;
    wait_cyc(2);
    check(rst_out_n == 1'b0, "R10 fault overrides wait", int'(rst_out_n), 0);
    pb_level = 1'b1;
    wait_cyc(10);
    pwr_good = 1'b1;
    wait_cyc(PULSE + 10);
    check(rst_out_n == 1'b1, "R10 recovery", int'(rst_out_n), 1);

    // random mix, checked every cycle by the model
    cur_req = "R8";
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      ms_tick = ($urandom % 4) != 0;
      if (($urandom % 600) == 0) pb_level = ~pb_level;
      wd_strobe_n = ($urandom % 40) != 0;
      cfg_we = ($urandom % 3000) == 0;
      cfg_period = 2'($urandom % 4);
      if (!pwr_good) pwr_good = ($urandom % 30) == 0;
      else pwr_good = ($urandom % 8000) != 0;
    end
    ms_tick = 1'b1; cfg_we = 1'b0; pwr_good = 1'b1; pb_level = 1'b1;
    wait_cyc(10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule